// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block is a bank of general-purpose I/O lines that software drives and watches through a small memory-mapped register set. Each line is an output or an input. Output lines present a latched value with an enable. Input lines are brought into the core clock through a two-flop synchronizer. Each input line can raise an interrupt on a rising edge or on a falling edge, and the polarity is chosen per line.

A level change on an input that is configured, unmasked and of the selected polarity sets a sticky status bit. The single interrupt output stays high while any status bit is set. Software clears status bits by writing ones to them. A pin-enable register gates which synchronized inputs are seen when software reads the input data.

The bus is a plain strobe interface with a write flag, a byte address, a width code and 16-bit data. Read data is combinational while a valid read is presented. Only accesses with the half-word width code take effect.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, pin_out is 0xFFFF, pin_oe is 0x0000 and irq is 0. A read of the status register (0x14) returns 0, a read of the input data register (0x00) returns 0, and reads of output latch (0x04), direction (0x08), polarity (0x0C), mask (0x10) and pin-enable (0x18) all return 0xFFFF.
- R2: A write with width code 1 to 0x04, 0x08, 0x0C, 0x10 or 0x18 stores the 16-bit data. A later read with width code 1 at the same offset returns that data.
- R3: From the first clock edge that commits a write to 0x04 or 0x08, pin_out equals the output latch and pin_oe bit i is 1 exactly when direction bit i is 0. A direction bit of 1 makes the line an input.
- R4: A read of 0x00 returns the synchronized pin levels ANDed with the pin-enable register. A pin level present before clock edge k becomes readable after edge k+1, and not after edge k.
- R5: On an input line with polarity bit 1, a rising edge sets the status bit, and with polarity bit 0 a falling edge sets it. The opposite edge sets nothing. A pin change present before edge k sets status (and irq) at edge k+2.
- R6: An edge sets a status bit only when that line's direction bit is 1 and its mask bit is 0.
- R7: Status bits stay set until cleared. A write with width code 1 to 0x14 clears each bit written as 1 and leaves bits written as 0 unchanged.
- R8: irq is 1 while any status bit is set, and it goes low only when every status bit is clear.
- R9: When a qualifying edge and a clearing write hit the same status bit in the same cycle, the bit stays set. Other bits in that write are still cleared.
- R10: Writes to 0x00 change no register and no output.
- R11: Accesses with a width code other than 1 (0 byte, 2 word, 3 reserved) have no effect. Such writes change nothing, including status, and such reads return 0.
- R12: Reads of any offset other than the seven defined ones return 0, and writes to such offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_width | input | 2 | Access width code: 0 byte, 1 half-word, 2 word, 3 reserved |
| bus_wdata | input | N_LINES | Write data |
| bus_rdata | output | N_LINES | Read data, valid while a read is presented |
| pin_in | input | N_LINES | Asynchronous line levels from the pads |
| pin_out | output | N_LINES | Output latch value per line |
| pin_oe | output | N_LINES | Per-line output enable, high for output lines |
| irq | output | 1 | Aggregated interrupt, high while any status bit is set |

## Verification
The bench sweeps every line through all eight combinations of direction, mask and polarity. It drives the triggering edge and then the opposite edge, so a design that swapped polarity, ignored the mask or let output lines interrupt would set the wrong status bit. Cycle-exact probes cover the two-stage input delay and the three-edge interrupt latency, where an extra or a missing register would show the level one cycle off. The bench lines up an edge with a clearing write in the same cycle, where a design that lets the clear win would lose the event. Further checks send writes to the input register, writes with the wrong width and writes to unused offsets, and a decoder that accepted any of them would change the output latch, direction or status.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_RSVD = 2'd3
  } acc_width_e;

  localparam logic [7:0] OFS_DIN  = 8'h00;
  localparam logic [7:0] OFS_DOUT = 8'h04;
  localparam logic [7:0] OFS_DIR  = 8'h08;
  localparam logic [7:0] OFS_POL  = 8'h0C;
  localparam logic [7:0] OFS_MSK  = 8'h10;
  localparam logic [7:0] OFS_STS  = 8'h14;
  localparam logic [7:0] OFS_PEN  = 8'h18;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned N_LINES = 16,
  parameter int unsigned STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] async_i,
  output logic [N_LINES-1:0] sync_o
);

  logic [N_LINES-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [N_LINES-1:0] stg_d;
    if (g == 0) begin : g_first
      assign stg_d = async_i;
    end else begin : g_next
      assign stg_d = stg_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q[g] <= '0;
      end else begin
        stg_q[g] <= stg_d;
      end
    end
  end

  assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int unsigned N_LINES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] smp_i,
  input  logic [N_LINES-1:0] dir_i,
  input  logic [N_LINES-1:0] mask_i,
  input  logic [N_LINES-1:0] pol_i,
  output logic [N_LINES-1:0] evt_o
);

  logic [N_LINES-1:0] prev_q, prev_d;
  logic [N_LINES-1:0] rise, fall, hit;

  always_comb begin
    prev_d = smp_i;
    rise   = smp_i & ~prev_q;
    fall   = ~smp_i & prev_q;
    hit    = (pol_i & rise) | (~pol_i & fall);
    evt_o  = hit & dir_i & ~mask_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= prev_d;
    end
  end

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_edge_pkg::*;
#(
  parameter int unsigned N_LINES = 16,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [1:0]         bus_width,
  input  logic [N_LINES-1:0] bus_wdata,
  output logic [N_LINES-1:0] bus_rdata,
  input  logic [N_LINES-1:0] smp_i,
  input  logic [N_LINES-1:0] evt_i,
  output logic [N_LINES-1:0] out_o,
  output logic [N_LINES-1:0] dir_o,
  output logic [N_LINES-1:0] pol_o,
  output logic [N_LINES-1:0] mask_o,
  output logic [N_LINES-1:0] pen_o,
  output logic [N_LINES-1:0] sts_o
);

  localparam logic [ADDR_W-1:0] A_DIN  = ADDR_W'(OFS_DIN);
  localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'(OFS_DOUT);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(OFS_POL);
  localparam logic [ADDR_W-1:0] A_MSK  = ADDR_W'(OFS_MSK);
  localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(OFS_STS);
  localparam logic [ADDR_W-1:0] A_PEN  = ADDR_W'(OFS_PEN);

  logic [N_LINES-1:0] out_q, out_d;
  logic [N_LINES-1:0] dir_q, dir_d;
  logic [N_LINES-1:0] pol_q, pol_d;
  logic [N_LINES-1:0] msk_q, msk_d;
  logic [N_LINES-1:0] pen_q, pen_d;
  logic [N_LINES-1:0] sts_q, sts_d;
  logic [N_LINES-1:0] clr;
  logic               acc_ok, wr_en, rd_en;
  logic               en_out, en_dir, en_pol, en_msk, en_pen;

  // access qualification
  always_comb begin
    acc_ok = bus_sel && (bus_width == ACC_HALF);
    wr_en  = acc_ok && bus_wr;
    rd_en  = acc_ok && !bus_wr;
    en_out = wr_en && (bus_addr == A_DOUT);
    en_dir = wr_en && (bus_addr == A_DIR);
    en_pol = wr_en && (bus_addr == A_POL);
    en_msk = wr_en && (bus_addr == A_MSK);
    en_pen = wr_en && (bus_addr == A_PEN);
    clr    = (wr_en && (bus_addr == A_STS)) ? bus_wdata : '0;
  end

  // next state: new events override a same-cycle clear
  always_comb begin
    out_d = en_out ? bus_wdata : out_q;
    dir_d = en_dir ? bus_wdata : dir_q;
    pol_d = en_pol ? bus_wdata : pol_q;
    msk_d = en_msk ? bus_wdata : msk_q;
    pen_d = en_pen ? bus_wdata : pen_q;
    sts_d = (sts_q & ~clr) | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '1;
      dir_q <= '1;
      pol_q <= '1;
      msk_q <= '1;
      pen_q <= '1;
      sts_q <= '0;
    end else begin
      out_q <= out_d;
      dir_q <= dir_d;
      pol_q <= pol_d;
      msk_q <= msk_d;
      pen_q <= pen_d;
      sts_q <= sts_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (bus_addr)
        A_DIN:   bus_rdata = smp_i & pen_q;
        A_DOUT:  bus_rdata = out_q;
        A_DIR:   bus_rdata = dir_q;
        A_POL:   bus_rdata = pol_q;
        A_MSK:   bus_rdata = msk_q;
        A_STS:   bus_rdata = sts_q;
        A_PEN:   bus_rdata = pen_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign out_o  = out_q;
  assign dir_o  = dir_q;
  assign pol_o  = pol_q;
  assign mask_o = msk_q;
  assign pen_o  = pen_q;
  assign sts_o  = sts_q;

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl #(
  parameter int unsigned N_LINES     = 16,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [1:0]         bus_width,
  input  logic [N_LINES-1:0] bus_wdata,
  output logic [N_LINES-1:0] bus_rdata,
  input  logic [N_LINES-1:0] pin_in,
  output logic [N_LINES-1:0] pin_out,
  output logic [N_LINES-1:0] pin_oe,
  output logic               irq
);

  logic [N_LINES-1:0] smp, evt;
  logic [N_LINES-1:0] out_w, dir_w, pol_w, mask_w, pen_w, sts_w;

  gpio_sync #(.N_LINES(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_in),
    .sync_o  (smp)
  );

  gpio_edge_det #(.N_LINES(N_LINES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .smp_i  (smp),
    .dir_i  (dir_w),
    .mask_i (mask_w),
    .pol_i  (pol_w),
    .evt_o  (evt)
  );

  gpio_regs #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_width (bus_width),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .smp_i     (smp),
    .evt_i     (evt),
    .out_o     (out_w),
    .dir_o     (dir_w),
    .pol_o     (pol_w),
    .mask_o    (mask_w),
    .pen_o     (pen_w),
    .sts_o     (sts_w)
  );

  assign pin_out = out_w;
  assign pin_oe  = ~dir_w;
  assign irq     = |sts_w;

endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk
  import gpio_edge_pkg::*;
#(
  parameter int unsigned N_LINES = 16,
  parameter int unsigned ADDR_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [1:0]         bus_width,
  input logic [N_LINES-1:0] bus_wdata,
  input logic [N_LINES-1:0] bus_rdata,
  input logic [N_LINES-1:0] pin_out,
  input logic [N_LINES-1:0] pin_oe,
  input logic               irq,
  input logic [N_LINES-1:0] dir_w,
  input logic [N_LINES-1:0] mask_w,
  input logic [N_LINES-1:0] pol_w,
  input logic [N_LINES-1:0] pen_w,
  input logic [N_LINES-1:0] sts_w
);

  logic half, wr_dir, wr_sts, wr_din, bad_wr, bad_rd, undef_addr;

  always_comb begin
    half       = bus_width == ACC_HALF;
    wr_dir     = bus_sel && bus_wr && half && (bus_addr == ADDR_W'(OFS_DIR));
    wr_sts     = bus_sel && bus_wr && half && (bus_addr == ADDR_W'(OFS_STS));
    wr_din     = bus_sel && bus_wr && half && (bus_addr == ADDR_W'(OFS_DIN));
    bad_wr     = bus_sel && bus_wr && !half;
    bad_rd     = bus_sel && !bus_wr && !half;
    undef_addr = !(bus_addr == ADDR_W'(OFS_DIN)  || bus_addr == ADDR_W'(OFS_DOUT) ||
                   bus_addr == ADDR_W'(OFS_DIR)  || bus_addr == ADDR_W'(OFS_POL)  ||
                   bus_addr == ADDR_W'(OFS_MSK)  || bus_addr == ADDR_W'(OFS_STS)  ||
                   bus_addr == ADDR_W'(OFS_PEN));
  end

  // R3
  oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> pin_oe == ~$past(bus_wdata));

  // R6
  gated_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_w & ~$past(sts_w) & ~($past(dir_w) & ~$past(mask_w))) == '0);

  // R7
  sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sts |=> (sts_w & $past(sts_w)) == $past(sts_w));

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_sts) |=> irq);

  // R10
  din_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_din |=> ($stable(pin_out) && $stable(dir_w) && $stable(pol_w) &&
                $stable(mask_w) && $stable(pen_w)));

  // R11
  bad_width_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> ($stable(pin_out) && $stable(dir_w) && $stable(pol_w) &&
                $stable(mask_w) && $stable(pen_w) &&
                ((sts_w & $past(sts_w)) == $past(sts_w))));

  // R11
  bad_width_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_rd |-> bus_rdata == '0);

  // R12
  undef_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && undef_addr) |-> bus_rdata == '0);

endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_width (bus_width),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .dir_w     (dir_w),
  .mask_w    (mask_w),
  .pol_w     (pol_w),
  .pen_w     (pen_w),
  .sts_w     (sts_w)
);

// File: tb/test_gpio_edge_ctrl.sv
`timescale 1ns/1ps
module test_gpio_edge_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        b_sel, b_wr;
  logic [7:0]  b_addr;
  logic [1:0]  b_width;
  logic [15:0] b_wdata, b_rdata;
  logic [15:0] pin_in, pin_out, pin_oe;
  logic        irq;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  gpio_edge_ctrl i_gpio_edge_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (b_sel),
    .bus_wr    (b_wr),
    .bus_addr  (b_addr),
    .bus_width (b_width),
    .bus_wdata (b_wdata),
    .bus_rdata (b_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [15:0] d, input logic [1:0] w = 2'd1);
    @(negedge clk);
    b_sel = 1'b1; b_wr = 1'b1; b_addr = a; b_wdata = d; b_width = w;
    @(negedge clk);
    b_sel = 1'b0; b_wr = 1'b0;
  endtask

  task automatic bread(input logic [7:0] a, output logic [15:0] d, input logic [1:0] w = 2'd1);
    @(negedge clk);
    b_sel = 1'b1; b_wr = 1'b0; b_addr = a; b_width = w;
    #5;
    d = b_rdata;
    b_sel = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] rd, v, d;
    logic [7:0]  rw_ofs [5];
    rw_ofs[0] = 8'h04; rw_ofs[1] = 8'h08; rw_ofs[2] = 8'h0C;
    rw_ofs[3] = 8'h10; rw_ofs[4] = 8'h18;
    rst_n = 1'b0; b_sel = 1'b0; b_wr = 1'b0; b_addr = '0; b_width = 2'd1;
    b_wdata = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 pin_out", pin_out, 16'hFFFF);
    check("R1 pin_oe", pin_oe, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'h0000);
    bread(8'h00, rd); check("R1 din", rd, 16'h0000);
    bread(8'h14, rd); check("R1 status", rd, 16'h0000);
    for (int k = 0; k < 5; k++) begin
      bread(rw_ofs[k], rd); check("R1 reg", rd, 16'hFFFF);
    end

    // R2 write/read-back sweep
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 5; k++) begin
        v = 16'(16'h3C5A * (p + 1) + k * 16'h0101);
        bwrite(rw_ofs[k], v);
        bread(rw_ofs[k], rd); check("R2 readback", rd, v);
      end
    end
    bwrite(8'h10, 16'hFFFF);
    bwrite(8'h14, 16'hFFFF);

    // R3 output drive
    for (int p = 0; p < 6; p++) begin
      v = 16'(16'h1357 * (p + 3));
      d = 16'(16'h0F0F << p) ^ 16'h8001;
      bwrite(8'h04, v);
      check("R3 pin_out", pin_out, v);
      bwrite(8'h08, d);
      check("R3 pin_oe", pin_oe, ~d);
    end

    // R4 input read-back with pin enable, and timing
    bwrite(8'h08, 16'hFFFF);
    bwrite(8'h10, 16'hFFFF);
    for (int p = 0; p < 5; p++) begin
      v = 16'(16'hA5A5 >> p) ^ 16'(p * 16'h1111);
      d = 16'(16'hFF00 >> (p * 2));
      pin_in = v;
      settle();
      bwrite(8'h18, d);
      bread(8'h00, rd); check("R4 din&pen", rd, v & d);
    end
    bwrite(8'h18, 16'hFFFF);
    @(negedge clk);
    pin_in = 16'h00F0;
    bread(8'h00, rd); check("R4 one edge", rd, v);
    bread(8'h00, rd); check("R4 two edges", rd, 16'h00F0);
    pin_in = '0;
    settle();
    bwrite(8'h14, 16'hFFFF);

    // R5/R6 per-line sweep of direction, mask, polarity
    for (int i = 0; i < 16; i++) begin
      for (int c = 0; c < 8; c++) begin
        logic dir_b, msk_b, pol_b, fire;
        logic [15:0] bit_v;
        dir_b = c[0]; msk_b = c[1]; pol_b = c[2];
        bit_v = 16'(1) << i;
        fire  = dir_b && !msk_b;
        bwrite(8'h08, dir_b ? bit_v : 16'h0000);
        bwrite(8'h10, msk_b ? bit_v : 16'h0000);
        bwrite(8'h0C, pol_b ? 16'hFFFF : 16'h0000);
        pin_in = pol_b ? 16'h0000 : bit_v;
        settle();
        bwrite(8'h14, 16'hFFFF);
        pin_in = pin_in ^ bit_v;
        settle();
        bread(8'h14, rd);
        if (fire) check("R5 edge sets status", rd, bit_v);
        else      check("R6 gated line no status", rd, 16'h0000);
        check("R8 irq follows status", {15'd0, irq}, {15'd0, fire});
        bwrite(8'h14, 16'hFFFF);
        pin_in = pin_in ^ bit_v;
        settle();
        bread(8'h14, rd); check("R5 opposite edge ignored", rd, 16'h0000);
      end
    end

    // R5 exact latency
    pin_in = '0;
    bwrite(8'h08, 16'h0003);
    bwrite(8'h10, 16'h0000);
    bwrite(8'h0C, 16'hFFFF);
    settle();
    bwrite(8'h14, 16'hFFFF);
    @(negedge clk);
    pin_in = 16'h0001;
    @(negedge clk); check("R5 irq after 1 edge", {15'd0, irq}, 16'h0000);
    @(negedge clk); check("R5 irq after 2 edges", {15'd0, irq}, 16'h0000);
    @(negedge clk); check("R5 irq after 3 edges", {15'd0, irq}, 16'h0001);

    // R7/R8 sticky status and irq aggregation
    pin_in = 16'h0003;
    settle();
    bread(8'h14, rd); check("R7 both set", rd, 16'h0003);
    bwrite(8'h14, 16'h0000);
    bread(8'h14, rd); check("R7 zero write keeps", rd, 16'h0003);
    bwrite(8'h14, 16'h0001);
    bread(8'h14, rd); check("R7 partial clear", rd, 16'h0002);
    check("R8 irq stays", {15'd0, irq}, 16'h0001);
    bwrite(8'h14, 16'h0002);
    check("R8 irq drops", {15'd0, irq}, 16'h0000);

    // R9 event beats same-cycle clear
    pin_in = 16'h0000;
    settle();
    bwrite(8'h14, 16'hFFFF);
    pin_in = 16'h0002;
    settle();
    @(negedge clk);
    pin_in = 16'h0003;
    @(negedge clk);
    bwrite(8'h14, 16'h0003);
    bread(8'h14, rd); check("R9 event wins", rd, 16'h0001);

    // R11 wrong width
    bwrite(8'h14, 16'hFFFF, 2'd0);
    bread(8'h14, rd); check("R11 byte clear ignored", rd, 16'h0001);
    bwrite(8'h04, 16'h1234);
    for (int w = 0; w < 4; w++) begin
      if (w != 1) begin
        bwrite(8'h04, 16'hBEEF, 2'(w));
        check("R11 out unchanged", pin_out, 16'h1234);
        bread(8'h08, rd, 2'(w)); check("R11 read zero", rd, 16'h0000);
      end
    end

    // R10 data input write ignored
    bwrite(8'h00, 16'h0000);
    check("R10 pin_out", pin_out, 16'h1234);
    check("R10 pin_oe", pin_oe, 16'hFFFC);
    bread(8'h00, rd); check("R10 din", rd, 16'h0003);
    bread(8'h18, rd); check("R10 pen", rd, 16'hFFFF);

    // R12 undefined offsets
    bread(8'h1C, rd); check("R12 read 1C", rd, 16'h0000);
    bread(8'h02, rd); check("R12 read 02", rd, 16'h0000);
    bread(8'h40, rd); check("R12 read 40", rd, 16'h0000);
    bwrite(8'h1C, 16'h0000);
    bwrite(8'h06, 16'h0000);
    check("R12 pin_out", pin_out, 16'h1234);
    bread(8'h08, rd); check("R12 dir", rd, 16'h0003);
    bread(8'h14, rd); check("R12 status", rd, 16'h0001);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule